// File: doc/BRIEF.md
# Video Sync Input Timing Decoder

This block turns externally supplied horizontal sync, vertical sync (or odd/even field) and an optional blank line into the frame position used by a video encoder whose timing is driven from outside. All three inputs are registered on the block clock, and edges are found by comparing the newest sample with the one before it. A two-bit mode select decides which relation between the vertical and horizontal inputs counts as a field boundary. At each boundary the block reports which field has begun, reloads its line counter and emits a one-clock retrace pulse.

A standard select picks 525-line or 625-line numbering. It sets the line number at which the second field begins, the count at which each field is expected to begin, and the lines that are blanked automatically when the external blank input is not in use. A field boundary that arrives at the wrong count raises a sticky error flag, and the counters still follow the new boundary.

Top module: `sync_timing_decoder`

## Requirements
- R1: Inputs are registered once. A sync change that is present at clock edge k affects field_o, line_o and vretrace_o after edge k+1. Reset leaves horizontal sync sampled high and vertical sync and blank sampled low.
- R2: With mode_sel = 1, any change of vsync_i seen while the sampled hsync_i is low starts a field. field_o takes the new vsync_i level (0 = first field, 1 = second field).
- R3: With mode_sel = 2, a falling vsync_i seen while hsync_i is low starts the first field (field_o = 0), and a falling vsync_i seen while hsync_i is high starts the second field (field_o = 1). Rising vsync_i edges do nothing.
- R4: With mode_sel = 3, any change of vsync_i seen while hsync_i is high starts a field, and field_o takes the new vsync_i level.
- R5: With mode_sel = 0, and for any vertical edge that does not qualify under the selected mode, no field starts: field_o and vretrace_o do not change and line_o keeps counting.
- R6: A field start loads line_o with 1 for the first field, or with 263 (std_625 = 0) or 313 (std_625 = 1) for the second field. Each falling hsync_i edge adds one, saturating at the counter maximum. When a field start and a falling hsync_i edge are seen in the same sample, the field start wins.
- R7: vretrace_o is high for exactly the clock after each field start, and is low otherwise.
- R8: From the second field start after reset, the count that a start replaces (plus one if a falling hsync_i edge is seen in the same sample) must equal the second-field start line for a second field, or the total line count plus one (526 or 626) for a first field. Any other value sets timing_err_o, which stays set until reset.
- R9: With ext_blank_en = 0, blank_o is high one clock after line_o holds a line in 1..21 or 263..284 (std_625 = 0), or in 1..22 or 311..335 (std_625 = 1).
- R10: With ext_blank_en = 1, blank_o is the active-high blank_i, delayed by the same two edges as R1.
- R11: Under synchronous reset, field_o, line_o, vretrace_o, blank_o and timing_err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_i | input | 1 | External horizontal sync, active low |
| vsync_i | input | 1 | External vertical sync or field signal |
| blank_i | input | 1 | External blank, active high |
| ext_blank_en | input | 1 | 1 = use blank_i, 0 = generate blanking from the line count |
| mode_sel | input | 2 | Field recognition mode (0 off, 1, 2, 3) |
| std_625 | input | 1 | 0 = 525-line, 1 = 625-line numbering |
| field_o | output | 1 | Current field (0 first, 1 second) |
| line_o | output | LINE_W | Frame line number |
| vretrace_o | output | 1 | One-clock pulse at each field start |
| blank_o | output | 1 | Blanking output, active high |
| timing_err_o | output | 1 | Sticky misplaced-field-start flag |

## Verification
A field start and a line increment can fall in the same sample when the vertical input changes on the same clock as the horizontal falling edge. The bench drives exactly that case in mode 1 at the correct position in the frame. It then expects line_o to reload to the field's start line rather than step, and expects timing_err_o to stay low, because the edge being counted at the same time brings the replaced count up to the expected value. A reference model updated on every clock judges the same cycle independently.

// File: rtl/sync_dec_pkg.sv
package sync_dec_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_TOG_HLO = 2'd1,
    MODE_FALL    = 2'd2,
    MODE_TOG_HHI = 2'd3
  } sync_mode_e;

  typedef struct packed {
    logic hs;
    logic vs;
    logic blank;
  } sync_smp_t;

  typedef struct packed {
    logic start;
    logic second;
  } fstart_t;

  localparam sync_smp_t SMP_RST = '{hs: 1'b1, vs: 1'b0, blank: 1'b0};

endpackage

// File: rtl/sync_in_sampler.sv
module sync_in_sampler
  import sync_dec_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  sync_smp_t raw,
  output sync_smp_t cur,
  output sync_smp_t prv
);
  localparam int LAST = DEPTH - 1;

  sync_smp_t stage [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= SMP_RST;
          else     stage[0] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= SMP_RST;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign cur = stage[LAST-1];
  assign prv = stage[LAST];
endmodule

// File: rtl/sync_field_detect.sv
module sync_field_detect
  import sync_dec_pkg::*;
(
  input  logic [1:0] mode_sel,
  input  sync_smp_t  cur,
  input  sync_smp_t  prv,
  output fstart_t    fs,
  output logic       hs_fall
);
  logic vs_change;
  logic vs_drop;

  assign hs_fall   = prv.hs & ~cur.hs;
  assign vs_change = cur.vs ^ prv.vs;
  assign vs_drop   = prv.vs & ~cur.vs;

  always_comb begin
    fs = '0;
    unique case (sync_mode_e'(mode_sel))
      MODE_TOG_HLO: begin
        fs.start  = vs_change & ~cur.hs;
        fs.second = cur.vs;
      end
      MODE_FALL: begin
        fs.start  = vs_drop;
        fs.second = cur.hs;
      end
      MODE_TOG_HHI: begin
        fs.start  = vs_change & cur.hs;
        fs.second = cur.vs;
      end
      default: fs = '0;
    endcase
  end
endmodule

// File: rtl/sync_line_tracker.sv
module sync_line_tracker
  import sync_dec_pkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int TOTAL_525 = 525,
  parameter int TOTAL_625 = 625,
  parameter int SEC_525   = 263,
  parameter int SEC_625   = 313
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              std_625,
  input  fstart_t           fs,
  input  logic              hs_fall,
  output logic [LINE_W-1:0] line,
  output logic              field,
  output logic              vret,
  output logic              err
);
  localparam logic [LINE_W-1:0] LMAX   = {LINE_W{1'b1}};
  localparam logic [LINE_W-1:0] FIRST  = LINE_W'(1);
  localparam logic [LINE_W-1:0] S525   = LINE_W'(SEC_525);
  localparam logic [LINE_W-1:0] S625   = LINE_W'(SEC_625);
  localparam logic [LINE_W-1:0] WRAP525 = LINE_W'(TOTAL_525 + 1);
  localparam logic [LINE_W-1:0] WRAP625 = LINE_W'(TOTAL_625 + 1);

  logic              locked;
  logic [LINE_W-1:0] sec_start;
  logic [LINE_W-1:0] expect_cnt;
  logic [LINE_W-1:0] bumped;
  logic [LINE_W-1:0] replaced;

  assign sec_start  = std_625 ? S625 : S525;
  assign expect_cnt = fs.second ? sec_start : (std_625 ? WRAP625 : WRAP525);
  assign bumped     = (line == LMAX) ? line : line + 1'b1;
  assign replaced   = hs_fall ? bumped : line;

  always_ff @(posedge clk) begin
    if (rst) begin
      line   <= '0;
      field  <= 1'b0;
      vret   <= 1'b0;
      err    <= 1'b0;
      locked <= 1'b0;
    end else begin
      vret <= fs.start;
      if (fs.start) begin
        line   <= fs.second ? sec_start : FIRST;
        field  <= fs.second;
        locked <= 1'b1;
        if (locked && (replaced != expect_cnt)) err <= 1'b1;
      end else if (hs_fall) begin
        line <= bumped;
      end
    end
  end
endmodule

// File: rtl/sync_blank_gen.sv
module sync_blank_gen #(
  parameter int LINE_W  = 10,
  parameter int NRANGE  = 2,
  parameter int LO_525 [NRANGE] = '{1, 263},
  parameter int HI_525 [NRANGE] = '{21, 284},
  parameter int LO_625 [NRANGE] = '{1, 311},
  parameter int HI_625 [NRANGE] = '{22, 335}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              std_625,
  input  logic              ext_en,
  input  logic              ext_blank,
  input  logic [LINE_W-1:0] line,
  output logic              blank
);
  logic [NRANGE-1:0] hit;

  generate
    for (genvar r = 0; r < NRANGE; r++) begin : g_rng
      localparam logic [LINE_W-1:0] A_LO = LINE_W'(LO_525[r]);
      localparam logic [LINE_W-1:0] A_HI = LINE_W'(HI_525[r]);
      localparam logic [LINE_W-1:0] B_LO = LINE_W'(LO_625[r]);
      localparam logic [LINE_W-1:0] B_HI = LINE_W'(HI_625[r]);
      assign hit[r] = std_625 ? (line >= B_LO && line <= B_HI)
                              : (line >= A_LO && line <= A_HI);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) blank <= 1'b0;
    else     blank <= ext_en ? ext_blank : |hit;
  end
endmodule

// File: rtl/sync_timing_decoder.sv
module sync_timing_decoder
  import sync_dec_pkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int TOTAL_525 = 525,
  parameter int TOTAL_625 = 625,
  parameter int SEC_525   = 263,
  parameter int SEC_625   = 313
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              blank_i,
  input  logic              ext_blank_en,
  input  logic [1:0]        mode_sel,
  input  logic              std_625,
  output logic              field_o,
  output logic [LINE_W-1:0] line_o,
  output logic              vretrace_o,
  output logic              blank_o,
  output logic              timing_err_o
);
  sync_smp_t raw_s;
  sync_smp_t cur_s;
  sync_smp_t prv_s;
  fstart_t   fs;
  logic      hs_fall;

  assign raw_s = '{hs: hsync_i, vs: vsync_i, blank: blank_i};

  sync_in_sampler #(.DEPTH(2)) u_smp (
    .clk (clk),
    .rst (rst),
    .raw (raw_s),
    .cur (cur_s),
    .prv (prv_s)
  );

  sync_field_detect u_det (
    .mode_sel (mode_sel),
    .cur      (cur_s),
    .prv      (prv_s),
    .fs       (fs),
    .hs_fall  (hs_fall)
  );

  sync_line_tracker #(
    .LINE_W    (LINE_W),
    .TOTAL_525 (TOTAL_525),
    .TOTAL_625 (TOTAL_625),
    .SEC_525   (SEC_525),
    .SEC_625   (SEC_625)
  ) u_trk (
    .clk     (clk),
    .rst     (rst),
    .std_625 (std_625),
    .fs      (fs),
    .hs_fall (hs_fall),
    .line    (line_o),
    .field   (field_o),
    .vret    (vretrace_o),
    .err     (timing_err_o)
  );

  sync_blank_gen #(.LINE_W(LINE_W)) u_blk (
    .clk       (clk),
    .rst       (rst),
    .std_625   (std_625),
    .ext_en    (ext_blank_en),
    .ext_blank (cur_s.blank),
    .line      (line_o),
    .blank     (blank_o)
  );
endmodule

// File: rtl/sync_timing_decoder_chk.sv
module sync_timing_decoder_chk #(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              blank_i,
  input logic              ext_blank_en,
  input logic [1:0]        mode_sel,
  input logic              field_o,
  input logic [LINE_W-1:0] line_o,
  input logic              vretrace_o,
  input logic              blank_o,
  input logic              timing_err_o
);
  localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    timing_err_o |=> timing_err_o);

  assert_first_field_line_R6: assert property (@(posedge clk) disable iff (rst)
    (vretrace_o && !field_o) |-> (line_o == ONE));

  assert_line_step_R6: assert property (@(posedge clk) disable iff (rst)
    (line_o != $past(line_o)) |-> (vretrace_o || line_o == $past(line_o) + ONE));

  assert_mode_off_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'd0) |=> !vretrace_o);

  assert_ext_blank_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(ext_blank_en) && !$past(rst) && !$past(rst, 2))
      |-> (blank_o == $past(blank_i, 2)));
endmodule

bind sync_timing_decoder sync_timing_decoder_chk #(.LINE_W(LINE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .blank_i      (blank_i),
  .ext_blank_en (ext_blank_en),
  .mode_sel     (mode_sel),
  .field_o      (field_o),
  .line_o       (line_o),
  .vretrace_o   (vretrace_o),
  .blank_o      (blank_o),
  .timing_err_o (timing_err_o)
);

// File: tb/sync_timing_decoder_test.sv
module sync_timing_decoder_test;
  localparam int LW = 10;
  localparam int LMAX = (1 << LW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hs = 1'b1, vs = 1'b0, bl = 1'b0, ext = 1'b0, std = 1'b0;
  logic [1:0] mode = 2'd1;
  logic field_o, vret_o, blank_o, err_o;
  logic [LW-1:0] line_o;

  int n_cmp = 0, n_bad = 0, cycles = 0;

  always #4 clk = ~clk;

  sync_timing_decoder #(.LINE_W(LW)) uut (
    .clk(clk), .rst(rst), .hsync_i(hs), .vsync_i(vs), .blank_i(bl),
    .ext_blank_en(ext), .mode_sel(mode), .std_625(std),
    .field_o(field_o), .line_o(line_o), .vretrace_o(vret_o),
    .blank_o(blank_o), .timing_err_o(err_o)
  );

  // behavioural reference: history of two input samples plus frame state
  int m_line, m_field, m_vret, m_err, m_blank, m_lock;
  logic h1, v1, b1, h2, v2;

  function automatic int in_blank(int ln, logic s625);
    if (s625) return int'((ln >= 1 && ln <= 22) || (ln >= 311 && ln <= 335));
    return int'((ln >= 1 && ln <= 21) || (ln >= 263 && ln <= 284));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_line = 0; m_field = 0; m_vret = 0; m_err = 0; m_blank = 0; m_lock = 0;
      h1 = 1; v1 = 0; b1 = 0; h2 = 1; v2 = 0;
    end else begin
      int nb, bump, rep, sec_ln, tgt;
      bit fall, st, sec;
      fall = h2 && !h1;
      st = 0; sec = 0;
      case (mode)
        2'd1: if (v1 != v2 && !h1) begin st = 1; sec = v1; end
        2'd2: if (v2 && !v1) begin st = 1; sec = h1; end
        2'd3: if (v1 != v2 && h1) begin st = 1; sec = v1; end
        default: st = 0;
      endcase
      sec_ln = std ? 313 : 263;
      nb = ext ? int'(b1) : in_blank(m_line, std);
      bump = (m_line == LMAX) ? m_line : m_line + 1;
      if (st) begin
        rep = fall ? bump : m_line;
        tgt = sec ? sec_ln : (std ? 626 : 526);
        if (m_lock != 0 && rep != tgt) m_err = 1;
        m_line = sec ? sec_ln : 1;
        m_field = int'(sec);
        m_lock = 1;
      end else if (fall) begin
        m_line = bump;
      end
      m_vret = int'(st);
      m_blank = nb;
      h2 = h1; v2 = v1;
      h1 = hs; v1 = vs; b1 = bl;
    end
  end

  function automatic string ftag();
    if (rst) return "R11";
    case (mode)
      2'd1: return "R2";
      2'd2: return "R3";
      2'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    cmp(ftag(), "field_o", int'(field_o), m_field);
    cmp(rst ? "R11" : "R6", "line_o", int'(line_o), m_line);
    cmp(rst ? "R11" : "R7 (R1 latency)", "vretrace_o", int'(vret_o), m_vret);
    cmp(rst ? "R11" : "R8", "timing_err_o", int'(err_o), m_err);
    cmp(rst ? "R11" : (ext ? "R10" : "R9"), "blank_o", int'(blank_o), m_blank);
  end

  // one line: hsync low for 2 clocks, high for 4; vsync set at clock 'at'
  task automatic run_line(int at, logic vval);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      hs = (c < 2) ? 1'b0 : 1'b1;
      if (c == at) vs = vval;
      bl = (c == 3) ? ~bl : bl;
    end
  endtask

  task automatic run_lines(int n);
    for (int k = 0; k < n; k++) run_line(-1, 1'b0);
  endtask

  task automatic do_reset(logic [1:0] m, logic s, logic e, logic v0);
    @(negedge clk);
    rst = 1'b1; hs = 1'b1; vs = v0; mode = m; std = s; ext = e; bl = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    // R11 reset state, R1/R2 mode 1 on 525 lines, R9 auto blanking
    do_reset(2'd1, 1'b0, 1'b0, 1'b0);
    run_lines(3);
    run_line(1, 1'b1);          // first start: second field at 263
    run_lines(262);
    run_line(1, 1'b0);          // first field on time
    run_lines(261);
    run_line(0, 1'b1);          // R6 collision: vsync change with hsync fall
    run_lines(262);
    run_line(1, 1'b0);
    run_line(3, 1'b1);          // R5: change while hsync high ignored in mode 1
    run_lines(2);
    run_line(3, 1'b0);
    run_lines(10);
    run_line(1, 1'b1);          // R8: early second field sets error
    run_lines(5);
    run_line(1, 1'b0);          // error stays set

    // R4 mode 3 on 625 lines
    do_reset(2'd3, 1'b1, 1'b0, 1'b0);
    run_lines(2);
    run_line(3, 1'b1);
    run_lines(312);
    run_line(3, 1'b0);
    run_lines(311);
    run_line(3, 1'b1);
    run_line(1, 1'b0);          // change while hsync low ignored in mode 3
    run_lines(4);

    // R3 mode 2 on 625 lines: falling edges only
    do_reset(2'd2, 1'b1, 1'b0, 1'b1);
    run_lines(2);
    run_line(1, 1'b0);          // first field
    run_line(4, 1'b1);          // rising ignored
    run_lines(310);
    run_line(3, 1'b0);          // second field at 313, on time
    run_line(4, 1'b1);
    run_lines(311);
    run_line(1, 1'b0);

    // R5 mode 0, R10 external blank
    do_reset(2'd0, 1'b0, 1'b1, 1'b0);
    run_lines(4);
    run_line(1, 1'b1);
    run_line(3, 1'b0);
    run_lines(30);

    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_200_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule